// File: doc/BRIEF.md
# Fractional-N Divide Sequence Generator

This block runs at the comparison (reference) rate of a fractional-N synthesizer. On every clock it hands the dual-modulus feedback divider a whole-number divide value. Over time the mean of those values equals a programmed integer word plus a 24-bit fractional word.

A third-order cascade of three first-order accumulators (MASH 1-1-1) spreads the rounding error across the sequence. The error ends up as noise at high offsets, where the loop filter removes it. Each cycle the cascade produces a small signed correction, and the block adds it to the integer part.

A frequency-modulation path can add a signed offset to the programmed value before the cascade sees it. The offset is a two's-complement word scaled by a power-of-two step. A two-bit mode input chooses how the offset is applied:
- it is off,
- a frequency-shift-keying pin switches it in and out, or
- it is applied all the time, and software rewrites the word to steer the frequency continuously.

Top module: `fracn_seq_gen`

## Requirements
- R1: While `rstN` is low, `divOut` is 0, the stored modulation word is 0 and all accumulators are cleared. After release with a zero fraction and no offset, the first output equals `intWord`.
- R2: With `fracWord` = 0 and no offset applied, `divOut` equals `intWord` on every cycle. `divOut` is a register that reflects the inputs sampled at the previous rising edge.
- R3: When no offset is applied, `divOut` lies between `intWord`-3 and `intWord`+4 on every cycle. This is the range of the third-order correction.
- R4: With a constant configuration, the mean of `divOut` over 65536 consecutive cycles equals `intWord + fracWord/2^24` to within 2^-12.
- R5: With `modeSel` = 2'b11 (FSK), `fskIn` high adds an offset of `wrWord * 2^(modStep+8)` units of 2^-24 to the programmed value, where `wrWord` is the stored word read as two's complement. `fskIn` low gives the nominal value. A change on the pin shows in the output one clock later.
- R6: A high `wrStb` stores `wrData` at the rising edge. With `modeSel` = 2'b01 (continuous), the stored word is applied all the time. A word written at one edge governs the output that follows the next edge.
- R7: With `modeSel` = 2'b00, the stored word, `modStep` and `fskIn` have no effect on `divOut`.
- R8: With `modeSel` = 2'b10, the block behaves as in mode 2'b00, with no offset applied.
- R9: The offset and the fraction are added as one wide number. A sum of 2^24 or more carries into the integer part, and a negative sum borrows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intWord | input | INT_W (9) | Integer part of the divide ratio, at least 4 |
| fracWord | input | FRAC_W (24) | Fractional part of the divide ratio, in units of 2^-24 |
| modeSel | input | 2 | 00 off, 01 continuous, 10 off, 11 FSK |
| modStep | input | STEP_W (3) | Power-of-two scale applied to the modulation word |
| fskIn | input | 1 | FSK select: high applies the offset in mode 11 |
| wrStb | input | 1 | Write strobe for the modulation word |
| wrData | input | MOD_W (16) | Two's-complement modulation word |
| divOut | output | INT_W+2 (11) | Divide value for the current reference cycle |

## Verification
The bench builds the block with its default parameters: a 9-bit integer word, a 24-bit fraction, a 16-bit modulation word and a 3-bit step. With these values, a step of 7 and a word of 0x0200 move the ratio by exactly one integer unit. The FSK, continuous-write, carry and borrow cases therefore settle to constant, easily predicted divide values, with the accumulators held at zero. A 65536-cycle run with an irregular fraction tests the long-term mean against the 2^-12 tolerance. Dithered runs with small negative offsets are compared cycle by cycle against an integer model of the cascade.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
  localparam int FRAC_BITS    = 24;
  localparam int DEV_DEN_BITS = 16;
  localparam int MASH_ORDER   = 3;

  typedef enum logic [1:0] {
    MOD_OFF  = 2'b00,
    MOD_CONT = 2'b01,
    MOD_RSVD = 2'b10,
    MOD_FSK  = 2'b11
  } modMode_t;

  typedef struct packed {
    logic applyDev;
  } pathCtl_t;
endpackage

// File: rtl/fracn_mod_ctrl.sv
`timescale 1ns/1ps
module fracn_mod_ctrl
  import fracn_pkg::*;
#(
  parameter int MOD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             fskIn,
  input  logic             wrStb,
  input  logic [MOD_W-1:0] wrData,
  output logic [MOD_W-1:0] modWordQ,
  output pathCtl_t         pathCtl
);
  modMode_t mode;
  assign mode = modMode_t'(modeSel);

  // Stored word is loaded by the strobe in every mode (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      modWordQ <= '0;
    else if (wrStb) modWordQ <= wrData;
  end

  always_comb begin
    pathCtl = '0;
    case (mode)
      MOD_CONT: pathCtl.applyDev = 1'b1;
      MOD_FSK:  pathCtl.applyDev = fskIn;
      default:  pathCtl.applyDev = 1'b0;
    endcase
  end
endmodule

// File: rtl/fracn_div_path.sv
`timescale 1ns/1ps
module fracn_div_path
  import fracn_pkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = FRAC_BITS,
  parameter int MOD_W  = 16,
  parameter int STEP_W = 3,
  parameter int DEN_W  = DEV_DEN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic [MOD_W-1:0]  modWord,
  input  logic [STEP_W-1:0] modStep,
  input  pathCtl_t          pathCtl,
  output logic [INT_W+1:0]  divOut
);
  localparam int SUM_W   = INT_W + FRAC_W + 2;
  localparam int EINT_W  = INT_W + 2;
  localparam int SH_BASE = FRAC_W - DEN_W;
  localparam int ORDER   = MASH_ORDER;

  // Offset merged with the programmed value as one wide signed number
  logic signed [SUM_W-1:0] modExt, devOff, nomWord, effWord;
  logic [EINT_W-1:0]       effIntBits;
  logic [FRAC_W-1:0]       effFrac;

  assign modExt     = SUM_W'(signed'(modWord));
  assign devOff     = pathCtl.applyDev ? (modExt <<< (SH_BASE + int'(modStep))) : '0;
  assign nomWord    = SUM_W'({intWord, fracWord});
  assign effWord    = nomWord + devOff;
  assign effIntBits = effWord[SUM_W-1:FRAC_W];
  assign effFrac    = effWord[FRAC_W-1:0];

  // Cascade of first-order accumulators
  logic [FRAC_W:0] stageSum   [ORDER];
  logic            stageCarry [ORDER];

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic [FRAC_W-1:0] accQ;
    logic [FRAC_W-1:0] stageIn;
    if (i == 0) begin : g_first
      assign stageIn = effFrac;
    end else begin : g_next
      assign stageIn = stageSum[i-1][FRAC_W-1:0];
    end
    assign stageSum[i]   = {1'b0, accQ} + {1'b0, stageIn};
    assign stageCarry[i] = stageSum[i][FRAC_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ <= '0;
      else       accQ <= stageSum[i][FRAC_W-1:0];
    end
  end

  // Difference filters on the second and third carries
  logic c2Q, c3Q, c3QQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Q  <= 1'b0;
      c3Q  <= 1'b0;
      c3QQ <= 1'b0;
    end else begin
      c2Q  <= stageCarry[1];
      c3Q  <= stageCarry[2];
      c3QQ <= c3Q;
    end
  end

  logic [3:0]        corr;
  logic [EINT_W-1:0] divSum;
  assign corr = 4'(stageCarry[0]) + 4'(stageCarry[1]) - 4'(c2Q)
              + 4'(stageCarry[2]) - {2'b00, c3Q, 1'b0} + 4'(c3QQ);
  assign divSum = effIntBits + {{(EINT_W-4){corr[3]}}, corr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divOut <= '0;
    else       divOut <= divSum;
  end
endmodule

// File: rtl/fracn_seq_gen.sv
`timescale 1ns/1ps
module fracn_seq_gen
  import fracn_pkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = FRAC_BITS,
  parameter int MOD_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic [1:0]        modeSel,
  input  logic [STEP_W-1:0] modStep,
  input  logic              fskIn,
  input  logic              wrStb,
  input  logic [MOD_W-1:0]  wrData,
  output logic [INT_W+1:0]  divOut
);
  logic [MOD_W-1:0] modWordQ;
  pathCtl_t         pathCtl;

  fracn_mod_ctrl #(.MOD_W(MOD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .fskIn(fskIn),
    .wrStb(wrStb), .wrData(wrData), .modWordQ(modWordQ), .pathCtl(pathCtl)
  );

  fracn_div_path #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .MOD_W(MOD_W),
    .STEP_W(STEP_W), .DEN_W(DEV_DEN_BITS)
  ) u_path (
    .clk(clk), .rstN(rstN), .intWord(intWord), .fracWord(fracWord),
    .modWord(modWordQ), .modStep(modStep), .pathCtl(pathCtl), .divOut(divOut)
  );
endmodule

// File: rtl/fracn_seq_chk.sv
`timescale 1ns/1ps
module fracn_seq_chk #(
  parameter int INT_W = 9,
  parameter int MOD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic [INT_W-1:0] intWord,
  input logic             wrStb,
  input logic [MOD_W-1:0] wrData,
  input logic [MOD_W-1:0] modWordQ,
  input logic             applyDev,
  input logic [INT_W+1:0] divOut
);
  // R3: without offset the output stays within the correction range
  p_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    !applyDev |=> ((int'(divOut) + 3 >= int'($past(intWord))) &&
                   (int'(divOut) <= int'($past(intWord)) + 4)));

  // R6: strobe loads the word, otherwise it holds
  p_wr_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> (modWordQ == $past(wrData)));
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> $stable(modWordQ));

  // R7 / R8: modes 00 and 10 never enable the offset
  p_off_nodev_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) |-> !applyDev);
  p_rsvd_nodev_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10) |-> !applyDev);
endmodule

bind fracn_seq_gen fracn_seq_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .intWord(intWord),
  .wrStb(wrStb), .wrData(wrData), .modWordQ(modWordQ),
  .applyDev(pathCtl.applyDev), .divOut(divOut)
);

// File: tb/sim_fracn_seq_gen.sv
`timescale 1ns/1ps
module sim_fracn_seq_gen;
  localparam int INT_W = 9;
  localparam int OUT_W = INT_W + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  intWord = '0;
  logic [23:0] fracWord = '0;
  logic [1:0]  modeSel = 2'b00;
  logic [2:0]  modStep = '0;
  logic        fskIn = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic [10:0] divOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // Behavioural model state
  longint a1 = 0, a2 = 0, a3 = 0, mStored = 0;
  int     p2 = 0, p3 = 0, pp3 = 0;
  longint expOut = 0;
  localparam longint MASK24 = 64'hFFFFFF;

  always #2.5 clk = ~clk;

  fracn_seq_gen u0 (
    .clk(clk), .rstN(rstN), .intWord(intWord), .fracWord(fracWord),
    .modeSel(modeSel), .modStep(modStep), .fskIn(fskIn), .wrStb(wrStb),
    .wrData(wrData), .divOut(divOut)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // One clock: update the model from the applied inputs, compare after the edge
  task automatic cyc(input string tag);
    longint eff, ip, fr, dev;
    int c1, c2, c3, y;
    @(posedge clk);
    if (!rstN) begin
      a1 = 0; a2 = 0; a3 = 0; mStored = 0; p2 = 0; p3 = 0; pp3 = 0; expOut = 0;
    end else begin
      dev = 0;
      if (modeSel == 2'b01 || (modeSel == 2'b11 && fskIn))
        dev = mStored * (longint'(1) << (int'(modStep) + 8));
      eff = (longint'(intWord) << 24) + longint'(fracWord) + dev;
      ip  = eff >>> 24;
      fr  = eff & MASK24;
      a1 = a1 + fr; c1 = int'(a1 >> 24); a1 = a1 & MASK24;
      a2 = a2 + a1; c2 = int'(a2 >> 24); a2 = a2 & MASK24;
      a3 = a3 + a2; c3 = int'(a3 >> 24); a3 = a3 & MASK24;
      y = c1 + c2 - p2 + c3 - 2 * p3 + pp3;
      pp3 = p3; p3 = c3; p2 = c2;
      expOut = (ip + y) & ((longint'(1) << OUT_W) - 1);
      if (wrStb) mStored = longint'($signed(wrData));
    end
    #1;
    check(tag, divOut, expOut);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cyc("R1 reset");
    cyc("R1 reset");
    check("R1 reset output", divOut, 0);
    rstN = 1'b1;
  endtask

  initial begin
    longint sum, exact;
    int d, minD, maxD;
    @(negedge clk);
    intWord = 9'd40;
    doReset();
    cyc("R1 first");
    check("R1 first equals int", divOut, 40);

    repeat (16) cyc("R2");
    check("R2 integer only", divOut, 40);

    // R3 / R4: long dithered run
    fracWord = 24'h5A3C71;
    sum = 0; minD = 0; maxD = 0;
    for (int k = 0; k < 65536; k++) begin
      cyc("R3 sequence");
      d = int'(divOut) - 40;
      if (d < minD) minD = d;
      if (d > maxD) maxD = d;
      sum += longint'(divOut);
    end
    check("R3 min correction", (minD >= -3) ? 1 : 0, 1);
    check("R3 max correction", (maxD <= 4) ? 1 : 0, 1);
    exact = longint'(65536) * 40 * 256 + 24'h5A3C71;
    d = int'(sum * 256 - exact);
    check("R4 mean within 2^-12", (d <= 4096 && d >= -4096) ? 1 : 0, 1);

    // R7: mode 00 ignores word, step and pin
    intWord = 9'd60; fracWord = '0; modeSel = 2'b00; modStep = 3'd7;
    doReset();
    wrStb = 1'b1; wrData = 16'h0200;
    cyc("R7");
    wrStb = 1'b0;
    for (int k = 0; k < 8; k++) begin
      fskIn = k[0];
      cyc("R7");
      check("R7 no effect", divOut, 60);
    end

    // R5: FSK mode
    modeSel = 2'b11; fskIn = 1'b1;
    cyc("R5"); check("R5 pin high deviated", divOut, 61);
    cyc("R5"); check("R5 pin high held", divOut, 61);
    fskIn = 1'b0;
    cyc("R5"); check("R5 pin low nominal", divOut, 60);

    // R6: continuous mode, write latency
    modeSel = 2'b01;
    cyc("R6"); check("R6 stored word applied", divOut, 61);
    wrStb = 1'b1; wrData = 16'hFE00;
    cyc("R6"); check("R6 old word on write edge", divOut, 61);
    wrStb = 1'b0;
    cyc("R6"); check("R6 new word next edge", divOut, 59);

    // R8: reserved mode
    modeSel = 2'b10; fskIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc("R8");
      check("R8 reserved mode no offset", divOut, 60);
    end
    fskIn = 1'b0;

    // R9: carry and borrow across the integer boundary
    intWord = 9'd50; fracWord = '0; modeSel = 2'b00; modStep = 3'd7;
    doReset();
    wrStb = 1'b1; wrData = 16'h0300;
    cyc("R9"); check("R9 setup", divOut, 50);
    wrStb = 1'b0;
    fracWord = 24'h800000; modeSel = 2'b01;
    cyc("R9"); check("R9 carry into integer", divOut, 52);
    cyc("R9"); check("R9 carry held", divOut, 52);
    wrStb = 1'b1; wrData = 16'hFD00;
    cyc("R9"); check("R9 before borrow", divOut, 52);
    wrStb = 1'b0;
    cyc("R9"); check("R9 borrow from integer", divOut, 49);
    cyc("R9"); check("R9 borrow held", divOut, 49);

    // R9: dithered small negative offset
    fracWord = 24'h000100; modStep = 3'd0;
    wrStb = 1'b1; wrData = 16'hFFFE;
    cyc("R9 dither");
    wrStb = 1'b0;
    repeat (300) cyc("R9 dither");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule